// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural integer state of a small 32-bit RISC core: thirty-one general-purpose slots (the program counter among them), a current status register and five saved status registers, thirty-seven 32-bit words in all. The core addresses the register file with a 4-bit architectural index and a 5-bit processor mode. The block resolves which physical word each access reaches and stores the values. It does no decoding, arithmetic or exception sequencing.

There are two combinational read ports and one synchronous write port. A write in the same cycle as a read of the same physical word is forwarded to the read data. The fast-interrupt mode has private copies of indices 8 to 14. The other four exception modes each have private copies of indices 13 and 14 only. Every exception mode has its own saved status word. The system mode sees exactly the user-mode registers. A write-side override lets a privileged handler write the user-mode copy of a banked register.

The mode input passes through a single decode stage into a bank selector. That selector has six values: `BANK_USR`, `BANK_FIQ`, `BANK_IRQ`, `BANK_SVC`, `BANK_ABT` and `BANK_UND`. The block has no sequencing of its own. The bank selector is recomputed combinationally from `mode_i` every cycle, so any change from one mode to another takes effect immediately.

Top module: `rbank_regfile`

## Requirements
- R1: After reset every general-purpose register reads 0. The status register reads 0x000000D3, which is mode bits [4:0] = 10011 (supervisor) with IRQ-disable bit 7 and FIQ-disable bit 6 set.
- R2: The mode encodings are user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Any other encoding selects the user bank and has no saved status word.
- R3: Indices 0 to 7 and index 15 (program counter) name one shared register in every mode.
- R4: In fast-interrupt mode (10001), indices 8 to 14 name private registers that no other mode can read.
- R5: In interrupt, supervisor, abort and undefined modes, indices 13 and 14 are private to each mode. Indices 8 to 12 are shared with user mode.
- R6: System mode (11111) reads and writes exactly the user-mode registers.
- R7: Each of the five exception modes has its own saved status word, written by `spsr_wr_en` and read on `spsr_o`.
- R8: In user mode, system mode or an unlisted mode, a saved-status write changes no stored state, and `spsr_o` returns the current status register.
- R9: A general-purpose write takes effect at the rising clock edge. Reads are combinational. A write to the physical register being read in the same cycle appears on that read port before the edge.
- R10: With `wr_user_bank` high, the write port targets the user-mode copy of the addressed index in every mode. Reads still follow the current mode.
- R11: The status register is loaded from `cpsr_wr_data` at a clock edge with `cpsr_wr_en` high and holds otherwise.
- R12: The two read ports are independent and may address different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current processor mode |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General-purpose write enable |
| wr_idx | input | 4 | Write architectural index |
| wr_data | input | 32 | Write data |
| wr_user_bank | input | 1 | Direct the write to the user-mode copy |
| cpsr_wr_en | input | 1 | Status register write enable |
| cpsr_wr_data | input | 32 | Status register write data |
| cpsr_o | output | 32 | Current status register |
| spsr_wr_en | input | 1 | Saved status write enable for the current mode |
| spsr_wr_data | input | 32 | Saved status write data |
| spsr_o | output | 32 | Saved status word of the current mode, or the status register if the mode has none |

## Verification
A wrong bank mapping shows on the read port in the same cycle the index is presented. A write that went to the wrong physical slot shows as stale or foreign data at the first later read of either affected register. The bench therefore writes a distinct value through every mode and index pair, then reads every pair back. Any aliasing between banks then surfaces as a value tagged with the wrong mode. A broken saved-status select or a missing CPSR fallback shows on `spsr_o` the cycle after the write.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 4;
    localparam int MODE_W = 5;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5
    } bank_e;

    localparam int N_ARCH        = 1 << IDX_W;
    localparam int FIQ_LO        = 8;
    localparam int FIQ_HI        = 14;
    localparam int SP_IDX        = 13;
    localparam int LR_IDX        = 14;
    localparam int N_FIQ         = FIQ_HI - FIQ_LO + 1;
    localparam int N_SMALL       = LR_IDX - SP_IDX + 1;
    localparam int N_SMALL_BANKS = 4;
    localparam int SMALL_BASE    = N_ARCH + N_FIQ;
    localparam int N_GPR         = SMALL_BASE + N_SMALL * N_SMALL_BANKS;
    localparam int N_SPSR        = 5;
    localparam int PHYS_W        = $clog2(N_GPR);
    localparam int SPSR_W        = $clog2(N_SPSR);

    localparam logic [DATA_W-1:0] CPSR_RESET = 32'h0000_00D3;
endpackage

// File: rtl/rbank_mode_decode.sv
module rbank_mode_decode
    import rbank_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output bank_e             bank_o,
    output logic              has_spsr_o
);
    always_comb begin
        unique case (mode_i)
            MODE_FIQ: bank_o = BANK_FIQ;
            MODE_IRQ: bank_o = BANK_IRQ;
            MODE_SVC: bank_o = BANK_SVC;
            MODE_ABT: bank_o = BANK_ABT;
            MODE_UND: bank_o = BANK_UND;
            default:  bank_o = BANK_USR;
        endcase
        has_spsr_o = (bank_o != BANK_USR);
    end
endmodule

// File: rtl/rbank_index_map.sv
module rbank_index_map
    import rbank_pkg::*;
(
    input  bank_e              bank_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [PHYS_W-1:0]  phys_o
);
    int idx_c;
    int phys_c;

    always_comb begin
        idx_c  = int'(idx_i);
        phys_c = idx_c;
        unique case (bank_i)
            BANK_FIQ: begin
                if (idx_c >= FIQ_LO && idx_c <= FIQ_HI)
                    phys_c = N_ARCH + idx_c - FIQ_LO;
            end
            BANK_IRQ, BANK_SVC, BANK_ABT, BANK_UND: begin
                if (idx_c == SP_IDX || idx_c == LR_IDX)
                    phys_c = SMALL_BASE
                           + (int'(bank_i) - int'(BANK_IRQ)) * N_SMALL
                           + idx_c - SP_IDX;
            end
            default: ;
        endcase
        phys_o = PHYS_W'(phys_c);
    end
endmodule

// File: rtl/rbank_gpr_store.sv
module rbank_gpr_store
    import rbank_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic [PHYS_W-1:0]              waddr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    output logic [N_GPR-1:0][DATA_W-1:0]   regs_o
);
    logic [N_GPR-1:0][DATA_W-1:0] regs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (we_i) begin
            regs_q[waddr_i] <= wdata_i;
        end
    end

    assign regs_o = regs_q;

    p_addr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (int'(waddr_i) < N_GPR));

    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (regs_q[$past(waddr_i)] == $past(wdata_i)));

    p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(regs_q));
endmodule

// File: rtl/rbank_regfile.sv
module rbank_regfile
    import rbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic [3:0]        rd_a_idx,
    output logic [31:0]       rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [31:0]       rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [31:0]       wr_data,
    input  logic              wr_user_bank,
    input  logic              cpsr_wr_en,
    input  logic [31:0]       cpsr_wr_data,
    output logic [31:0]       cpsr_o,
    input  logic              spsr_wr_en,
    input  logic [31:0]       spsr_wr_data,
    output logic [31:0]       spsr_o
);
    localparam int N_RD = 2;

    bank_e                          cur_bank;
    bank_e                          wr_bank;
    logic                           has_spsr;
    logic [PHYS_W-1:0]              wr_phys;
    logic [N_GPR-1:0][DATA_W-1:0]   regs;
    logic [N_RD-1:0][IDX_W-1:0]     rd_idx;
    logic [N_RD-1:0][PHYS_W-1:0]    rd_phys;
    logic [N_RD-1:0][DATA_W-1:0]    rd_data;
    logic [DATA_W-1:0]              cpsr_q;
    logic [N_SPSR-1:0][DATA_W-1:0]  spsr_q;
    logic [SPSR_W-1:0]              spsr_sel;

    rbank_mode_decode u_decode (
        .mode_i     (mode_i),
        .bank_o     (cur_bank),
        .has_spsr_o (has_spsr)
    );

    assign wr_bank = wr_user_bank ? BANK_USR : cur_bank;

    rbank_index_map u_wr_map (
        .bank_i (wr_bank),
        .idx_i  (wr_idx),
        .phys_o (wr_phys)
    );

    rbank_gpr_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .waddr_i (wr_phys),
        .wdata_i (wr_data),
        .regs_o  (regs)
    );

    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        rbank_index_map u_rd_map (
            .bank_i (cur_bank),
            .idx_i  (rd_idx[p]),
            .phys_o (rd_phys[p])
        );
        assign rd_data[p] = (wr_en && (wr_phys == rd_phys[p])) ? wr_data
                                                                : regs[rd_phys[p]];
    end

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    assign spsr_sel = SPSR_W'(int'(cur_bank) - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpsr_q <= CPSR_RESET;
        end else if (cpsr_wr_en) begin
            cpsr_q <= cpsr_wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spsr_q <= '0;
        end else if (spsr_wr_en && has_spsr) begin
            spsr_q[spsr_sel] <= spsr_wr_data;
        end
    end

    assign cpsr_o = cpsr_q;
    assign spsr_o = has_spsr ? spsr_q[spsr_sel] : cpsr_q;

    p_spsr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spsr_wr_en && !has_spsr) |=> $stable(spsr_q));

    p_cpsr_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cpsr_wr_en |=> $stable(cpsr_q));

    p_cpsr_loads_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr_wr_en |=> (cpsr_o == $past(cpsr_wr_data)));

    p_forward_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_user_bank && (wr_idx == rd_a_idx)) |-> (rd_a_data == wr_data));

    p_shared_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx < 4'd8 || rd_a_idx == 4'd15) |-> (int'(rd_phys[0]) == int'(rd_a_idx)));
endmodule

// File: tb/rbank_regfile_tb.sv
module rbank_regfile_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = 5'b10000;
    logic [3:0]  rd_a_idx = '0;
    logic [31:0] rd_a_data;
    logic [3:0]  rd_b_idx = '0;
    logic [31:0] rd_b_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        wr_user_bank = 1'b0;
    logic        cpsr_wr_en = 1'b0;
    logic [31:0] cpsr_wr_data = '0;
    logic [31:0] cpsr_o;
    logic        spsr_wr_en = 1'b0;
    logic [31:0] spsr_wr_data = '0;
    logic [31:0] spsr_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] model [0:95];
    logic [31:0] spsr_model [0:5];
    logic [31:0] cpsr_model;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbank_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_user_bank(wr_user_bank),
        .cpsr_wr_en(cpsr_wr_en), .cpsr_wr_data(cpsr_wr_data), .cpsr_o(cpsr_o),
        .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data), .spsr_o(spsr_o)
    );

    // mode slot 0..7: user, fiq, irq, svc, abort, undef, system, unlisted
    function automatic logic [4:0] code_of(int m);
        case (m)
            0: return 5'b10000;
            1: return 5'b10001;
            2: return 5'b10010;
            3: return 5'b10011;
            4: return 5'b10111;
            5: return 5'b11011;
            6: return 5'b11111;
            default: return 5'b10100;
        endcase
    endfunction

    function automatic int bank_of(int m);
        if (m >= 1 && m <= 5) return m;
        return 0;
    endfunction

    function automatic int owner(int b, int idx);
        if (b == 1 && idx >= 8 && idx <= 14) return 1;
        if (b >= 2 && (idx == 13 || idx == 14)) return b;
        return 0;
    endfunction

    function automatic string req_of(int m, int idx);
        if (idx < 8 || idx == 15) return "R3";
        if (m == 1) return "R4";
        if (m >= 2 && m <= 5) return "R5";
        if (m == 6) return "R6";
        if (m == 7) return "R2";
        return "R3";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic write_gpr(int m, int idx, logic [31:0] d, bit user);
        @(negedge clk);
        mode_i = code_of(m); wr_idx = 4'(idx); wr_data = d;
        wr_user_bank = user; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_user_bank = 1'b0;
        model[(user ? 0 : owner(bank_of(m), idx)) * 16 + idx] = d;
    endtask

    task automatic read_pair(int m, int ia, int ib);
        @(negedge clk);
        mode_i = code_of(m); rd_a_idx = 4'(ia); rd_b_idx = 4'(ib);
        #1;
        check(req_of(m, ia), rd_a_data, model[owner(bank_of(m), ia) * 16 + ia]);
        check({req_of(m, ib), "/R12"}, rd_b_data, model[owner(bank_of(m), ib) * 16 + ib]);
    endtask

    initial begin
        for (int i = 0; i < 96; i++) model[i] = '0;
        for (int i = 0; i < 6; i++) spsr_model[i] = '0;
        cpsr_model = 32'h0000_00D3;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); mode_i = code_of(0); rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i); #1;
            check("R1", rd_a_data, 32'h0);
            check("R1", rd_b_data, 32'h0);
        end
        check("R1", cpsr_o, 32'h0000_00D3);
        check("R1", spsr_o, 32'h0000_00D3);

        // R2..R6: write a distinct value through every mode and index
        for (int m = 0; m < 8; m++)
            for (int i = 0; i < 16; i++)
                write_gpr(m, i, 32'hC000_0000 | (32'(m) << 12) | (32'(m * i) << 20) | 32'(i), 1'b0);
        for (int m = 0; m < 8; m++)
            for (int i = 0; i < 16; i++)
                read_pair(m, i, (i + 5) % 16);

        // R9: same-cycle forwarding in supervisor mode
        @(negedge clk);
        mode_i = code_of(3); wr_idx = 4'd13; wr_data = 32'h5A5A_0013; wr_en = 1'b1;
        rd_a_idx = 4'd13; rd_b_idx = 4'd13; #1;
        check("R9", rd_a_data, 32'h5A5A_0013);
        check("R9", rd_b_data, 32'h5A5A_0013);
        @(posedge clk); #1; wr_en = 1'b0;
        model[3 * 16 + 13] = 32'h5A5A_0013;
        read_pair(3, 13, 14);
        read_pair(0, 13, 14);

        // R10: user-bank override from fiq and irq
        write_gpr(1, 10, 32'hBEEF_000A, 1'b1);
        read_pair(0, 10, 9);
        read_pair(1, 10, 11);
        write_gpr(2, 13, 32'hBEEF_000D, 1'b1);
        read_pair(0, 13, 14);
        read_pair(2, 13, 14);
        write_gpr(1, 3, 32'hBEEF_0003, 1'b1);
        read_pair(5, 3, 15);

        // R7, R8: saved status per mode
        for (int m = 0; m < 8; m++) begin
            @(negedge clk);
            mode_i = code_of(m); spsr_wr_data = 32'h6000_0010 | 32'(m << 8); spsr_wr_en = 1'b1;
            @(posedge clk); #1; spsr_wr_en = 1'b0;
            if (bank_of(m) != 0) spsr_model[bank_of(m)] = 32'h6000_0010 | 32'(m << 8);
        end
        for (int m = 0; m < 8; m++) begin
            @(negedge clk); mode_i = code_of(m); #1;
            if (bank_of(m) != 0) check("R7", spsr_o, spsr_model[bank_of(m)]);
            else                 check("R8", spsr_o, cpsr_model);
        end

        // R11: status register load and hold
        @(negedge clk); cpsr_wr_data = 32'hF000_001F; cpsr_wr_en = 1'b1; #1;
        check("R11", cpsr_o, 32'h0000_00D3);
        @(posedge clk); #1; cpsr_wr_en = 1'b0; cpsr_model = 32'hF000_001F;
        check("R11", cpsr_o, 32'hF000_001F);
        @(negedge clk); cpsr_wr_data = 32'h1234_5678; #1;
        @(posedge clk); #1;
        check("R11", cpsr_o, 32'hF000_001F);
        @(negedge clk); mode_i = code_of(6); #1;
        check("R8", spsr_o, 32'hF000_001F);
        for (int m = 1; m < 6; m++) begin
            @(negedge clk); mode_i = code_of(m); #1;
            check("R7", spsr_o, spsr_model[m]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule